// File: doc/BRIEF.md
# Time-of-Day and Calendar Counter with Deferred Register Commit

This block keeps wall-clock time and the calendar date for a chip. It advances by one second on every cycle in which the one-cycle `sec_tick` enable is high. It handles minute, hour and day carries, the different month lengths, and leap years. The date runs from 1970-01-01 to 2033-12-31 through a 6-bit year offset. The word that holds the date also stores a leap flag. When the `LINEAR_DAY` parameter is set, the date word instead holds a 16-bit count of elapsed days.

Software talks to the block through a plain register port: a write strobe, an address, write data, and combinational read data. Writes to the time word or the date word are not applied at once. Each value is held in a stage register and loaded into the counters on the first seconds tick after the write. While a load is waiting, the busy flag for that word reads as 1 in the control word. A bus master is expected to wait until the control word's busy field (bits 9 down to 7) reads zero before it writes.

Top module: `tod_calendar`

## Requirements
- R1: After reset the time word reads 0 (00:00:00). The date word reads 0x00000101, which is day 1, month 1, offset 0, leap flag 0. The control word reads 0. In linear mode the date word reads 0 after reset.
- R2: The counters change only on a cycle with `sec_tick` high. Each such tick adds one second. The time word layout is seconds [5:0], minutes [13:8], hours [20:16], and all other bits read 0.
- R3: Seconds wrap from 59 to 0 and carry into minutes. Minutes wrap from 59 to 0 and carry into hours. Hours wrap from 23 to 0 and advance the date by one day.
- R4: The date word layout is day [4:0] (1-based), month [11:8] (1-based), year offset [21:16], leap flag [22]. April, June, September and November end after day 30. The other months, except February, end after day 31. At the end of a month the date moves to day 1 of the next month.
- R5: February ends after day 29 when the stored leap flag (bit 22) is 1, and after day 28 when it is 0.
- R6: December 31 rolls over to January 1 of the next year offset. The offset wraps from 63 to 0. On that rollover the leap flag is set to 1 exactly when (1970 + new offset) mod 4 == 0.
- R7: A write to address 1 (time) stages the value and sets control bit 8. Bit 8 stays set, and the time word keeps counting its old value, until the staged value is committed.
- R8: A write to address 2 (date) stages the value and sets control bit 7. The date word keeps its old value until the staged value is committed.
- R9: A staged value is committed on the first `sec_tick` after the cycle of the write. A tick in the same cycle as the write does not commit it. In the commit cycle the busy bit clears and the counter loads the staged value instead of incrementing.
- R10: The control word (address 0) reads 0 except for bits 8 and 7, and bit 9 always reads 0. A write to address 0 has no effect.
- R11: When a date commit and a midnight carry fall on the same tick, the committed date wins and the carry is discarded.
- R12: With `LINEAR_DAY` = 1 the date word holds a day count in bits [15:0]. A date write keeps only bits [15:0]. Each midnight carry adds 1 to the count, and 0xFFFF wraps to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-cycle enable, once per second |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register address: 0 control, 1 time, 2 date |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |

## Verification
The hardest cases to reach are the carries that ripple across every field at once. Examples are the last second of a year, of a leap February, and of year offset 63. Reaching them by counting would take months of simulated ticks. The bench instead uses the deferred write path: it stages a time just before midnight together with a chosen date, commits both with one tick, and then gives a single tick. The same path sets up the race between a date commit and a midnight carry. It also sets up the case of a write landing in the very cycle of a tick, where the commit must slip to the next tick.

// File: rtl/tod_pkg.sv
package tod_pkg;

  localparam int WORD_W     = 32;
  localparam int DATE_RAW_W = 23;
  localparam int EPOCH_YEAR = 1970;
  localparam int BUSY_DATE_BIT = 7;
  localparam int BUSY_TIME_BIT = 8;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_TIME = 2'd1,
    SEL_DATE = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic [4:0] hr;
    logic [5:0] min;
    logic [5:0] sec;
  } hms_t;

  typedef struct packed {
    logic       leap;
    logic [5:0] year;
    logic [3:0] mon;
    logic [4:0] day;
  } ymd_t;

  localparam int HMS_W = $bits(hms_t);

  function automatic logic [WORD_W-1:0] hms_to_word(input hms_t t);
    logic [WORD_W-1:0] w;
    w        = '0;
    w[5:0]   = t.sec;
    w[13:8]  = t.min;
    w[20:16] = t.hr;
    return w;
  endfunction

  function automatic hms_t word_to_hms(input logic [WORD_W-1:0] w);
    hms_t t;
    t.sec = w[5:0];
    t.min = w[13:8];
    t.hr  = w[20:16];
    return t;
  endfunction

  function automatic logic [WORD_W-1:0] ymd_to_word(input ymd_t d);
    logic [WORD_W-1:0] w;
    w        = '0;
    w[4:0]   = d.day;
    w[11:8]  = d.mon;
    w[21:16] = d.year;
    w[22]    = d.leap;
    return w;
  endfunction

  function automatic ymd_t raw_to_ymd(input logic [DATE_RAW_W-1:0] w);
    ymd_t d;
    d.day  = w[4:0];
    d.mon  = w[11:8];
    d.year = w[21:16];
    d.leap = w[22];
    return d;
  endfunction

  function automatic logic [4:0] month_days(input logic [3:0] mon, input logic leap);
    case (mon)
      4'd2:                    return leap ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11: return 5'd30;
      default:                 return 5'd31;
    endcase
  endfunction

  function automatic logic year_is_leap(input logic [5:0] off);
    int unsigned y;
    y = EPOCH_YEAR + int'(off);
    return (y % 4) == 0;
  endfunction

endpackage

// File: rtl/tod_stage.sv
module tod_stage #(
  parameter int W = 17
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         wr,
  input  logic [W-1:0] wval,
  output logic         busy,
  output logic [W-1:0] held,
  output logic         commit
);

  // A write always re-arms the stage; only a tick with no write drains it.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      held <= '0;
    end else if (wr) begin
      busy <= 1'b1;
      held <= wval;
    end else if (tick) begin
      busy <= 1'b0;
    end
  end

  // Commit uses the busy state from before this cycle's write.
  assign commit = tick & busy;

  assert_busy_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick) |=> busy);

  assert_busy_drain_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && tick && !wr) |=> !busy);

  assert_busy_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (busy && held == $past(wval)));

endmodule

// File: rtl/tod_hms.sv
module tod_hms
  import tod_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic load,
  input  hms_t ld,
  output hms_t cur,
  output logic day_carry
);

  logic sec_wrap;
  logic min_wrap;
  logic hr_wrap;

  // A field at or past its top value wraps, so that bad loaded values recover.
  assign sec_wrap  = cur.sec >= 6'd59;
  assign min_wrap  = cur.min >= 6'd59;
  assign hr_wrap   = cur.hr  >= 5'd23;
  assign day_carry = tick & ~load & sec_wrap & min_wrap & hr_wrap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur <= '0;
    end else if (load) begin
      cur <= ld;
    end else if (tick) begin
      cur.sec <= sec_wrap ? 6'd0 : cur.sec + 6'd1;
      if (sec_wrap) begin
        cur.min <= min_wrap ? 6'd0 : cur.min + 6'd1;
        if (min_wrap) begin
          cur.hr <= hr_wrap ? 5'd0 : cur.hr + 5'd1;
        end
      end
    end
  end

  assert_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cur));

  assert_sec_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && cur.sec == 6'd59) |=> (cur.sec == 6'd0));

  assert_midnight_R3: assert property (@(posedge clk) disable iff (!rst_n)
    day_carry |=> (cur.hr == 5'd0 && cur.min == 6'd0 && cur.sec == 6'd0));

  assert_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cur == $past(ld)));

endmodule

// File: rtl/tod_date.sv
module tod_date
  import tod_pkg::*;
#(
  parameter bit LINEAR_DAY = 1'b0,
  parameter int DAY_CNT_W  = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  day_step,
  input  logic                  load,
  input  logic [DATE_RAW_W-1:0] ld_raw,
  output logic [WORD_W-1:0]     word
);

  generate
    if (LINEAR_DAY) begin : g_linear
      logic [DAY_CNT_W-1:0] days;

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          days <= '0;
        end else if (load) begin
          days <= ld_raw[DAY_CNT_W-1:0];
        end else if (day_step) begin
          days <= days + 1'b1;
        end
      end

      assign word = WORD_W'(days);

      assert_lin_step_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (day_step && !load) |=> (days == DAY_CNT_W'($past(days) + 1'b1)));

    end else begin : g_calendar
      ymd_t       cur;
      logic [4:0] last_day;
      logic       month_end;
      logic       year_end;
      logic       year_step;
      logic [5:0] next_year;

      assign last_day  = month_days(cur.mon, cur.leap);
      assign month_end = cur.day >= last_day;
      assign year_end  = cur.mon >= 4'd12;
      assign next_year = cur.year + 6'd1;
      assign year_step = day_step & ~load & month_end & year_end;

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          cur      <= '0;
          cur.day  <= 5'd1;
          cur.mon  <= 4'd1;
          cur.leap <= year_is_leap(6'd0);
        end else if (load) begin
          cur <= raw_to_ymd(ld_raw);
        end else if (day_step) begin
          if (month_end) begin
            cur.day <= 5'd1;
            if (year_end) begin
              cur.mon  <= 4'd1;
              cur.year <= next_year;
              cur.leap <= year_is_leap(next_year);
            end else begin
              cur.mon <= cur.mon + 4'd1;
            end
          end else begin
            cur.day <= cur.day + 5'd1;
          end
        end
      end

      assign word = ymd_to_word(cur);

      assert_month_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (day_step && !load && month_end) |=> (cur.day == 5'd1));

      assert_leap_rule_R6: assert property (@(posedge clk) disable iff (!rst_n)
        year_step |=> (cur.leap == (cur.year[1:0] == 2'd2) && cur.mon == 4'd1));

      assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!day_step && !load) |=> $stable(cur));
    end
  endgenerate

endmodule

// File: rtl/tod_calendar.sv
module tod_calendar
  import tod_pkg::*;
#(
  parameter bit LINEAR_DAY = 1'b0,
  parameter int ADDR_W     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata
);

  logic        wr_time;
  logic        wr_date;
  logic        busy_time;
  logic        busy_date;
  logic        commit_time;
  logic        commit_date;
  logic [HMS_W-1:0]      time_held;
  logic [DATE_RAW_W-1:0] date_held;
  hms_t                  now_hms;
  logic                  day_carry;
  logic [WORD_W-1:0]     date_word;
  logic [WORD_W-1:0]     ctrl_word;

  assign wr_time = wr_en && (addr == ADDR_W'(SEL_TIME));
  assign wr_date = wr_en && (addr == ADDR_W'(SEL_DATE));

  tod_stage #(.W(HMS_W)) u_time_stage (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (sec_tick),
    .wr     (wr_time),
    .wval   (HMS_W'(word_to_hms(wdata))),
    .busy   (busy_time),
    .held   (time_held),
    .commit (commit_time)
  );

  tod_stage #(.W(DATE_RAW_W)) u_date_stage (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (sec_tick),
    .wr     (wr_date),
    .wval   (wdata[DATE_RAW_W-1:0]),
    .busy   (busy_date),
    .held   (date_held),
    .commit (commit_date)
  );

  tod_hms u_hms (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (sec_tick),
    .load      (commit_time),
    .ld        (hms_t'(time_held)),
    .cur       (now_hms),
    .day_carry (day_carry)
  );

  tod_date #(.LINEAR_DAY(LINEAR_DAY)) u_date (
    .clk      (clk),
    .rst_n    (rst_n),
    .day_step (day_carry),
    .load     (commit_date),
    .ld_raw   (date_held),
    .word     (date_word)
  );

  always_comb begin
    ctrl_word = '0;
    ctrl_word[BUSY_TIME_BIT] = busy_time;
    ctrl_word[BUSY_DATE_BIT] = busy_date;
  end

  always_comb begin
    case (addr)
      ADDR_W'(SEL_CTRL): rdata = ctrl_word;
      ADDR_W'(SEL_TIME): rdata = hms_to_word(now_hms);
      ADDR_W'(SEL_DATE): rdata = date_word;
      default:           rdata = '0;
    endcase
  end

  assert_time_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_time |=> busy_time);

  assert_date_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_date |=> busy_date);

  assert_date_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_date && day_carry) |=> (date_word[DATE_RAW_W-1:0] ==
      (LINEAR_DAY ? DATE_RAW_W'($past(date_held[15:0])) : $past(date_held) & 23'h7F_0F1F)));

endmodule

// File: tb/tod_calendar_bench.sv
module tod_calendar_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sec_tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [31:0] rdata_lin;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  tod_calendar u_tod_calendar (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  tod_calendar #(.LINEAR_DAY(1'b1)) u_tod_calendar_lin (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata_lin)
  );

  typedef struct packed {
    logic [31:0] t0;
    logic [31:0] d0;
    logic [7:0]  n;
    logic [31:0] t1;
    logic [31:0] d1;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{32'h0001_0203, 32'h0000_0101, 8'd1, 32'h0001_0204, 32'h0000_0101, 8'd2},  // R2
    '{32'h0000_003A, 32'h0000_0101, 8'd2, 32'h0000_0100, 32'h0000_0101, 8'd2},  // R2 two ticks
    '{32'h0000_003B, 32'h0000_0101, 8'd1, 32'h0000_0100, 32'h0000_0101, 8'd3},  // R3 sec carry
    '{32'h0005_3B3B, 32'h0000_0101, 8'd1, 32'h0006_0000, 32'h0000_0101, 8'd3},  // R3 hour carry
    '{32'h0017_3B3B, 32'h0000_0105, 8'd1, 32'h0000_0000, 32'h0000_0106, 8'd3},  // R3 day carry
    '{32'h0017_3B3B, 32'h0000_041E, 8'd1, 32'h0000_0000, 32'h0000_0501, 8'd4},  // R4 Apr 30
    '{32'h0017_3B3B, 32'h0000_011E, 8'd1, 32'h0000_0000, 32'h0000_011F, 8'd4},  // R4 Jan 30
    '{32'h0017_3B3B, 32'h0000_011F, 8'd1, 32'h0000_0000, 32'h0000_0201, 8'd4},  // R4 Jan 31
    '{32'h0017_3B3B, 32'h0000_021C, 8'd1, 32'h0000_0000, 32'h0000_0301, 8'd5},  // R5 Feb 28 plain
    '{32'h0017_3B3B, 32'h0042_021C, 8'd1, 32'h0000_0000, 32'h0042_021D, 8'd5},  // R5 Feb 28 leap
    '{32'h0017_3B3B, 32'h0042_021D, 8'd1, 32'h0000_0000, 32'h0042_0301, 8'd5},  // R5 Feb 29 leap
    '{32'h0017_3B3B, 32'h0001_0C1F, 8'd1, 32'h0000_0000, 32'h0042_0101, 8'd6},  // R6 into leap year
    '{32'h0017_3B3B, 32'h0042_0C1F, 8'd1, 32'h0000_0000, 32'h0003_0101, 8'd6},  // R6 out of leap year
    '{32'h0017_3B3B, 32'h003F_0C1F, 8'd1, 32'h0000_0000, 32'h0000_0101, 8'd6}   // R6 offset 63 wraps
  };

  task automatic check(input int req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic write_reg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk);
    sec_tick = 1'b1;
    @(negedge clk);
    sec_tick = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v, output logic [31:0] vl);
    addr = a;
    #1;
    v = rdata;
    vl = rdata_lin;
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    logic [31:0] vl;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd0, v, vl); check(1, "reset ctrl", v, 32'h0);
    rd(2'd1, v, vl); check(1, "reset time", v, 32'h0);
    rd(2'd2, v, vl); check(1, "reset date", v, 32'h0000_0101);
    check(1, "reset linear date", vl, 32'h0);

    // R7 time write is staged
    write_reg(2'd1, 32'h0002_0304);
    rd(2'd0, v, vl); check(7, "time busy set", v, 32'h0000_0100);
    rd(2'd1, v, vl); check(7, "time not yet applied", v, 32'h0);
    repeat (5) @(negedge clk);
    rd(2'd0, v, vl); check(7, "time busy held", v, 32'h0000_0100);

    // R9 commit on tick, no increment in commit cycle
    tick();
    rd(2'd0, v, vl); check(9, "busy cleared at commit", v, 32'h0);
    rd(2'd1, v, vl); check(9, "committed time", v, 32'h0002_0304);
    tick();
    rd(2'd1, v, vl); check(2, "count after commit", v, 32'h0002_0305);

    // R8 date write is staged
    write_reg(2'd2, 32'h0000_0305);
    rd(2'd0, v, vl); check(8, "date busy set", v, 32'h0000_0080);
    rd(2'd2, v, vl); check(8, "date not yet applied", v, 32'h0000_0101);
    tick();
    rd(2'd0, v, vl); check(8, "date busy cleared", v, 32'h0);
    rd(2'd2, v, vl); check(8, "committed date", v, 32'h0000_0305);
    rd(2'd1, v, vl); check(2, "time ticked with date commit", v, 32'h0002_0306);

    // R10 control writes ignored
    write_reg(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, v, vl); check(10, "control write ignored", v, 32'h0);
    rd(2'd1, v, vl); check(10, "time untouched", v, 32'h0002_0306);
    rd(2'd2, v, vl); check(10, "date untouched", v, 32'h0000_0305);

    // R9 write in same cycle as tick commits on the next tick
    @(negedge clk);
    wr_en = 1'b1; addr = 2'd2; wdata = 32'h0000_0707; sec_tick = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; sec_tick = 1'b0;
    rd(2'd0, v, vl); check(9, "same-cycle write still busy", v, 32'h0000_0080);
    rd(2'd2, v, vl); check(9, "same-cycle write not applied", v, 32'h0000_0305);
    tick();
    rd(2'd0, v, vl); check(9, "late commit busy cleared", v, 32'h0);
    rd(2'd2, v, vl); check(9, "late commit value", v, 32'h0000_0707);

    // R11 date commit beats midnight carry
    write_reg(2'd1, 32'h0017_3B3B);
    tick();
    write_reg(2'd2, 32'h0000_0A0A);
    tick();
    rd(2'd1, v, vl); check(11, "time at midnight", v, 32'h0);
    rd(2'd2, v, vl); check(11, "committed date kept", v, 32'h0000_0A0A);
    tick();
    rd(2'd2, v, vl); check(11, "no late carry", v, 32'h0000_0A0A);

    // Table walk over counting and calendar carries (R2..R6)
    for (int i = 0; i < NV; i++) begin
      write_reg(2'd1, VECS[i].t0);
      write_reg(2'd2, VECS[i].d0);
      tick();
      for (int k = 0; k < int'(VECS[i].n); k++) tick();
      rd(2'd1, v, vl); check(int'(VECS[i].req), $sformatf("vector %0d time", i), v, VECS[i].t1);
      rd(2'd2, v, vl); check(int'(VECS[i].req), $sformatf("vector %0d date", i), v, VECS[i].d1);
    end

    // R12 linear day count
    write_reg(2'd1, 32'h0017_3B3B);
    write_reg(2'd2, 32'h0001_FFFE);
    tick();
    rd(2'd2, v, vl); check(12, "linear load keeps 16 bits", vl, 32'h0000_FFFE);
    tick();
    rd(2'd2, v, vl); check(12, "linear midnight step", vl, 32'h0000_FFFF);
    write_reg(2'd1, 32'h0017_3B3B);
    tick();
    tick();
    rd(2'd2, v, vl); check(12, "linear wrap to zero", vl, 32'h0);
    rd(2'd1, v, vl); check(12, "linear time at midnight", vl, 32'h0);

    finish_run();
  end

endmodule